// File: doc/BRIEF.md
# I2C Write-Only Clock-Enable Controller

This block fans one reference clock out to eighteen gated copies and lets a two-wire serial host switch each copy on or off. The serial side is a receive-only slave. A faster system clock oversamples SCL and SDA, and the slave detects START and STOP. It acknowledges its own write address and then takes a fixed-order stream of bytes. The first two bytes after the address are placeholders that are acknowledged and thrown away. The bytes that follow fill three enable registers in strict order. There is no sub-address and no read-back.

A disabled copy is held low. An enabled copy follows the reference clock without inversion. A global output-enable input withdraws the drive of every copy, and the high-impedance state is modelled as a per-output drive flag that goes low. The open-drain SDA line is modelled as a single drive-low output.

Top module: `clkgate_i2c_ctrl`

## Requirements
- R1: After reset all 18 enables are 1, every `clk_out` bit follows `ref_clk`, and `sda_pull_low` is 0.
- R2: A START is SDA falling while SCL is high, and it begins a transfer. A STOP is SDA rising while SCL is high, and it ends the transfer. Bytes are 8 bits, MSB first, and each is followed by a ninth acknowledge clock.
- R3: When the first byte after START is 8'hD2 (address 7'b1101001 with a write bit of 0), the slave drives `sda_pull_low` high from the falling SCL edge after bit 8 until the falling edge that ends the ninth pulse.
- R4: A first byte other than 8'hD2 is not acknowledged. This includes 8'hD3, the read form. The slave then acknowledges nothing more and changes no enable until the next START.
- R5: The two bytes after an accepted address are acknowledged, and their values leave every enable unchanged.
- R6: The next data bytes go in order to register 0, register 1 and register 2. Register 0 bit k enables output k. Register 1 bit k enables output 8+k. Register 2 bit 7 enables output 17 and bit 6 enables output 16, and its bits 5..0 are ignored. A value of 1 enables the output.
- R7: An enabled output equals `ref_clk`. A disabled output is 0 while `ref_clk` is high and while it is low.
- R8: While `oe_in` is 0, every `clk_drive` bit is 0 (high impedance) whatever the enables hold. While `oe_in` is 1, every bit is 1.
- R9: Data bytes after the third are acknowledged and discarded.
- R10: A repeated START returns the byte position to the address byte, so the next data byte lands in register 0 again.
- R11: The enables change only in the cycle after a data byte is accepted into a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_pull_low | output | 1 | 1 = pull SDA low (acknowledge) |
| ref_clk | input | 1 | Reference clock to be fanned out |
| oe_in | input | 1 | 0 = withdraw drive from all outputs |
| clk_out | output | 18 | Gated copies of the reference clock |
| clk_drive | output | 18 | Per-output drive flag; 0 means high impedance |

## Verification
A wrong byte position or bit count shows up as a missing or misplaced acknowledge within the ninth SCL pulse of the affected byte. It can also show up as an enable pattern shifted into the wrong register, which is visible on `clk_out` as soon as the bytes end. A wrong enable bit is visible on the next high phase of `ref_clk`. An address decode that is too loose shows as an acknowledge on a foreign or read address, and as enables that change after that transfer. Random enable patterns and random transfer lengths are checked against a model of the bench's own, which drives register writes from the byte order alone. Directed cases cover the read address, a repeated START and surplus bytes.

// File: rtl/cgc_pkg.sv
`timescale 1ns/1ps
package cgc_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_BITS, RX_ACK} rx_state_e;

  // address, command placeholder, count placeholder
  localparam int HDR_BYTES = 3;
  localparam int BYTE_BITS = 8;

  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] a);
    return b == {a, 1'b0};
  endfunction
endpackage

// File: rtl/cgc_bus_sync.sv
`timescale 1ns/1ps
module cgc_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_p    <= scl_pipe[STAGES-1];
      sda_p    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = !scl_p && scl_s;
  assign scl_fall = scl_p && !scl_s;
  assign start_ev = scl_p && scl_s && sda_p && !sda_s;
  assign stop_ev  = scl_p && scl_s && !sda_p && sda_s;
endmodule

// File: rtl/cgc_i2c_rx.sv
`timescale 1ns/1ps
module cgc_i2c_rx
  import cgc_pkg::*;
#(
  parameter logic [6:0] ADDR = 7'b1101001,
  parameter int REGS  = 3,
  localparam int LAST_POS = HDR_BYTES + REGS,
  localparam int POS_W = $clog2(LAST_POS + 1),
  localparam int IDX_W = (REGS > 1) ? $clog2(REGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_ev,
  input  logic             stop_ev,
  output logic             pull_low,
  output logic             wr_fire,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic [POS_W-1:0] byte_pos
);
  rx_state_e  state;
  logic [3:0] bit_cnt;
  logic [7:0] shift;
  logic       byte_done, accept;

  assign byte_done = (state == RX_BITS) && scl_fall && (bit_cnt == 4'(BYTE_BITS));
  assign accept    = byte_done && ((byte_pos == '0) ? addr_hit(shift, ADDR) : 1'b1);
  assign wr_fire   = accept && (byte_pos >= POS_W'(HDR_BYTES)) && (byte_pos < POS_W'(LAST_POS));
  assign wr_idx    = IDX_W'(byte_pos - POS_W'(HDR_BYTES));
  assign wr_data   = shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      bit_cnt  <= '0;
      shift    <= '0;
      byte_pos <= '0;
      pull_low <= 1'b0;
    end else if (start_ev) begin
      state    <= RX_BITS;
      bit_cnt  <= '0;
      byte_pos <= '0;
      pull_low <= 1'b0;
    end else if (stop_ev) begin
      state    <= RX_IDLE;
      pull_low <= 1'b0;
    end else begin
      unique case (state)
        RX_BITS: begin
          if (scl_rise && bit_cnt < 4'(BYTE_BITS)) begin
            shift   <= {shift[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_done) begin
            if (accept) begin
              pull_low <= 1'b1;
              state    <= RX_ACK;
            end else begin
              state <= RX_IDLE;
            end
          end
        end
        RX_ACK: begin
          if (scl_fall) begin
            pull_low <= 1'b0;
            bit_cnt  <= '0;
            state    <= RX_BITS;
            if (byte_pos != POS_W'(LAST_POS)) byte_pos <= byte_pos + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cgc_en_regs.sv
`timescale 1ns/1ps
module cgc_en_regs #(
  parameter int OUTS  = 18,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  output logic [OUTS-1:0]  en
);
  localparam int REM  = OUTS % 8;
  localparam int LAST = (OUTS - 1) / 8;

  // a partly used last register takes its bits from the top down
  function automatic int bit_sel(input int i);
    if (REM != 0 && (i / 8) == LAST) return (i % 8) + (8 - REM);
    return i % 8;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= '1;
    end else if (wr_fire) begin
      for (int i = 0; i < OUTS; i++) begin
        if ((i / 8) == int'(wr_idx)) en[i] <= wr_data[bit_sel(i)];
      end
    end
  end
endmodule

// File: rtl/cgc_out_gate.sv
`timescale 1ns/1ps
module cgc_out_gate #(
  parameter int OUTS = 18
) (
  input  logic            ref_clk,
  input  logic            oe_in,
  input  logic [OUTS-1:0] en,
  output logic [OUTS-1:0] clk_out,
  output logic [OUTS-1:0] clk_drive
);
  for (genvar g = 0; g < OUTS; g++) begin : g_lane
    assign clk_out[g]   = ref_clk & en[g];
    assign clk_drive[g] = oe_in;
  end
endmodule

// File: rtl/clkgate_i2c_ctrl.sv
`timescale 1ns/1ps
module clkgate_i2c_ctrl
  import cgc_pkg::*;
#(
  parameter int         OUTS   = 18,
  parameter logic [6:0] ADDR   = 7'b1101001,
  parameter int         STAGES = 2,
  localparam int REGS  = (OUTS + 7) / 8,
  localparam int POS_W = $clog2(HDR_BYTES + REGS + 1),
  localparam int IDX_W = (REGS > 1) ? $clog2(REGS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_in,
  input  logic            sda_in,
  output logic            sda_pull_low,
  input  logic            ref_clk,
  input  logic            oe_in,
  output logic [OUTS-1:0] clk_out,
  output logic [OUTS-1:0] clk_drive
);
  logic             sda_s_w, scl_rise_w, scl_fall_w, start_w, stop_w;
  logic             wr_fire_w;
  logic [IDX_W-1:0] wr_idx_w;
  logic [7:0]       wr_data_w;
  logic [POS_W-1:0] byte_pos_w;
  logic [OUTS-1:0]  en_w;

  cgc_bus_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s_w), .scl_rise(scl_rise_w), .scl_fall(scl_fall_w),
    .start_ev(start_w), .stop_ev(stop_w)
  );

  cgc_i2c_rx #(.ADDR(ADDR), .REGS(REGS)) u_rx (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s_w),
    .scl_rise(scl_rise_w), .scl_fall(scl_fall_w),
    .start_ev(start_w), .stop_ev(stop_w),
    .pull_low(sda_pull_low), .wr_fire(wr_fire_w), .wr_idx(wr_idx_w),
    .wr_data(wr_data_w), .byte_pos(byte_pos_w)
  );

  cgc_en_regs #(.OUTS(OUTS), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire_w), .wr_idx(wr_idx_w),
    .wr_data(wr_data_w), .en(en_w)
  );

  cgc_out_gate #(.OUTS(OUTS)) u_gate (
    .ref_clk(ref_clk), .oe_in(oe_in), .en(en_w),
    .clk_out(clk_out), .clk_drive(clk_drive)
  );
endmodule

// File: rtl/cgc_checker.sv
`timescale 1ns/1ps
module cgc_checker #(
  parameter int OUTS  = 18,
  parameter int POS_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            oe_in,
  input logic            scl_fall,
  input logic            start_ev,
  input logic            stop_ev,
  input logic            sda_pull_low,
  input logic            wr_fire,
  input logic [POS_W-1:0] byte_pos,
  input logic [OUTS-1:0] en,
  input logic [OUTS-1:0] clk_out,
  input logic [OUTS-1:0] clk_drive
);
  p_ack_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_low != $past(sda_pull_low)) |-> $past(scl_fall || start_ev || stop_ev));

  p_ack_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_low) |-> $past(scl_fall) && ($past(byte_pos) <= POS_W'(6)));

  p_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_in |-> (clk_drive == '0));

  p_gate_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((clk_out & ~en) == '0));

  p_en_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_fire) |-> $stable(en));
endmodule

bind clkgate_i2c_ctrl cgc_checker #(.OUTS(OUTS), .POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_in(oe_in), .scl_fall(scl_fall_w),
  .start_ev(start_w), .stop_ev(stop_w), .sda_pull_low(sda_pull_low),
  .wr_fire(wr_fire_w), .byte_pos(byte_pos_w), .en(en_w),
  .clk_out(clk_out), .clk_drive(clk_drive)
);

// File: tb/sim_clkgate_i2c_ctrl.sv
`timescale 1ns/1ps
module sim_clkgate_i2c_ctrl;
  localparam int N = 18;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, ref_clk = 1'b0, oe = 1'b1;
  logic sda_bus, sda_pull_low;
  logic [N-1:0] clk_out, clk_drive;
  logic [N-1:0] exp_en;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  assign sda_bus = sda_m & ~sda_pull_low;

  always #2.5 clk = ~clk;

  clkgate_i2c_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
    .sda_pull_low(sda_pull_low), .ref_clk(ref_clk), .oe_in(oe),
    .clk_out(clk_out), .clk_drive(clk_drive)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench model of the register map
  function automatic logic [N-1:0] model_write(input logic [N-1:0] cur, input int reg_n, input logic [7:0] d);
    logic [N-1:0] r = cur;
    if (reg_n == 0) r[7:0] = d;
    else if (reg_n == 1) r[15:8] = d;
    else if (reg_n == 2) begin r[17] = d[7]; r[16] = d[6]; end
    return r;
  endfunction

  task automatic q();
    repeat (8) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl = 1'b1; q(); sda_m = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
    end
    sda_m = 1'b1; q(); scl = 1'b1; q();
    ack = !sda_bus;
    q(); scl = 1'b0; q();
  endtask

  task automatic check_outputs(input string req);
    ref_clk = 1'b1; @(negedge clk);
    chk(clk_out == exp_en, req, 32'(clk_out), 32'(exp_en));
    chk(clk_drive == {N{oe}}, "R8 drive", 32'(clk_drive), 32'({N{oe}}));
    ref_clk = 1'b0; @(negedge clk);
    chk(clk_out == '0, req, 32'(clk_out), 32'd0);
  endtask

  // one transfer: address, two placeholders, ndata data bytes
  task automatic run_txn(input logic [7:0] addr, input int ndata, input logic [39:0] dat, input string req);
    bit ack, ok;
    ok = (addr == 8'hD2);
    bus_start();
    send_byte(addr, ack);
    chk(ack == ok, ok ? "R3 addr ack" : "R4 addr nack", 32'(ack), 32'(ok));
    for (int k = 0; k < 2; k++) begin
      send_byte(8'($urandom), ack);
      chk(ack == ok, "R5 placeholder ack", 32'(ack), 32'(ok));
    end
    for (int i = 0; i < ndata; i++) begin
      send_byte(dat[8*i +: 8], ack);
      chk(ack == ok, (i >= 3) ? "R9 surplus ack" : "R6 data ack", 32'(ack), 32'(ok));
      if (ok) exp_en = model_write(exp_en, i, dat[8*i +: 8]);
    end
    bus_stop();
    check_outputs(req);
  endtask

  initial begin
    bit ack;
    void'($urandom(32'd2718));
    exp_en = '1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(sda_pull_low == 1'b0, "R1 sda released", 32'(sda_pull_low), 32'd0);
    check_outputs("R1 reset enables");

    // R6 full write with distinct patterns, reserved bits set
    run_txn(8'hD2, 3, 40'h00_3F_5A_C3_96, "R6 full write");
    run_txn(8'hD2, 3, 40'h00_C0_FF_00_FF, "R6 R7 pattern");
    // R5 placeholders only: nothing changes
    run_txn(8'hD2, 0, 40'h0, "R5 no data");
    // partial write: only register 0 moves
    run_txn(8'hD2, 1, 40'h0_00_00_00_A5, "R6 partial");
    // R4 foreign and read addresses
    run_txn(8'hD3, 3, 40'h0_00_00_00_00, "R4 read addr");
    run_txn(8'hA2, 3, 40'h0_00_00_00_00, "R4 foreign addr");
    // R9 surplus bytes
    run_txn(8'hD2, 5, 40'h11_22_80_0F_F0, "R9 surplus");

    // R10 repeated START
    bus_start();
    send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
    send_byte(8'h12, ack);
    exp_en = model_write(exp_en, 0, 8'h12);
    sda_m = 1'b1; q(); scl = 1'b1; q(); sda_m = 1'b0; q(); scl = 1'b0; q();
    send_byte(8'hD2, ack);
    chk(ack == 1'b1, "R10 readdress ack", 32'(ack), 32'd1);
    send_byte(8'h00, ack); send_byte(8'h00, ack);
    send_byte(8'h34, ack); exp_en = model_write(exp_en, 0, 8'h34);
    send_byte(8'h56, ack); exp_en = model_write(exp_en, 1, 8'h56);
    bus_stop();
    check_outputs("R10 restart position");

    // R2 R3 ack timing: pull low only across the ninth pulse
    bus_start();
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'(8'hD2 >> i); q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
    end
    chk(sda_pull_low == 1'b1, "R3 pull in slot", 32'(sda_pull_low), 32'd1);
    sda_m = 1'b1; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
    chk(sda_pull_low == 1'b0, "R3 release after slot", 32'(sda_pull_low), 32'd0);
    bus_stop();

    // R8 OE low
    oe = 1'b0;
    check_outputs("R8 hiz");
    oe = 1'b1;
    check_outputs("R8 drive back");

    // random transfers (R6 R7 R11)
    for (int t = 0; t < 14; t++) begin
      logic [7:0] a;
      a = ($urandom % 5 == 0) ? 8'($urandom) : 8'hD2;
      run_txn(a, $urandom % 5, {$urandom, 8'($urandom)}, "R11 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule